// File: doc/BRIEF.md
# Dual Reset Output Generator

This block drives two active-low reset lines, A and B, for a supervised power domain. Each line watches its own selectable subset of the per-rail undervoltage and overvoltage flags, and both lines react to a manual-reset pin and to a one-cycle timeout pulse from a long-period timer. When every trigger of a line has gone away, the line stays low for a programmable hold time and then goes high. When it goes high, a one-cycle release pulse is produced for the interrupt logic.

During power-on sequencing, line A can leave reset before line B. This happens when a chosen power-up enable rises while A is held only by its hold timer. All inputs are plain control pins that are already synchronous to `clk`. There is no data stream and no handshake. Comparators, the sequencer and the long timer are outside this block.

Top module: `dual_reset_gen`

## Requirements
- R1: While `rst_n` is low, both reset lines are low. After `rst_n` rises with no trigger present, both lines go high after exactly one full hold time, each with a release pulse.
- R2: The fault flags form an 8-bit vector with `uv_flag[i]` at bit i and `ov_flag[i]` at bit 4+i. A flag asserts a line only if the same bit of that line's mask (`mask_a` or `mask_b`) is 1. A flag whose mask bit is 0 leaves the line unaffected.
- R3: A line is low from the clock edge after a trigger appears. It stays low for exactly H clock edges after the last cycle in which a trigger was present, and then goes high.
- R4: `mr_n` low forces both lines low, regardless of the masks or any other setting, and the normal hold time follows when it returns high.
- R5: A `long_tmo` pulse asserts both lines for one hold time when `long_en` is 1. It has no effect when `long_en` is 0.
- R6: If any trigger of a line reappears before its hold time has elapsed, the hold count for that line starts over from zero.
- R7: When `pwr_on_seq` is 1, a rising edge on `pup_en[pup_sel]` releases line A at the next clock edge. This applies only if A is low and none of A's triggers is present. Line B is not affected.
- R8: The early release of line A does not occur in any of these cases: `pwr_on_seq` is 0, an unselected `pup_en` bit rises, a trigger of A is present, or A is already high. In the last case no release pulse is produced.
- R9: `rel_a` and `rel_b` pulse for exactly one cycle, in the first cycle in which the matching line is high after being low.
- R10: The hold time is H = PRTO_BASE << `tmo_sel` clock cycles. With the default settings this gives 8, 16, 32 or 64 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| uv_flag | input | NRAIL | Per-rail undervoltage flags |
| ov_flag | input | NRAIL | Per-rail overvoltage flags |
| mask_a | input | 2*NRAIL | Fault enable mask for line A |
| mask_b | input | 2*NRAIL | Fault enable mask for line B |
| mr_n | input | 1 | Manual reset, active low, cannot be masked |
| long_en | input | 1 | Enables the long-timer trigger |
| long_tmo | input | 1 | One-cycle long-timer timeout pulse |
| pwr_on_seq | input | 1 | High while power-on sequencing is in progress |
| pup_en | input | NPUP | Power-up enable signals from the sequencer |
| pup_sel | input | PUP_W | Index of the power-up enable that releases line A early |
| tmo_sel | input | TSEL_W | Hold time selector |
| rst_a_n | output | 1 | Reset line A, active low |
| rst_b_n | output | 1 | Reset line B, active low |
| rel_a | output | 1 | One-cycle pulse when line A is released |
| rel_b | output | 1 | One-cycle pulse when line B is released |

## Verification
Each line comes straight from one register. A trigger therefore pulls the line low one clock edge after it is applied, and an early release takes effect one edge after the `pup_en` rise. A hold-time release is seen H edges after the last trigger cycle, and the release pulse appears in that same cycle. The bench drives every input on the falling clock edge and samples on the next falling edge. Around every release it makes two checks: the line must still be low after H-1 edges and must be high, with its pulse, after H edges. The mask sweep covers all 64 pairs of selected bit and raised flag for both lines at once.

// File: rtl/drg_pkg.sv
package drg_pkg;
  localparam int NOUT = 2;
  localparam int CH_A = 0;
  localparam int CH_B = 1;

  function automatic int unsigned hold_len(input int unsigned base, input int unsigned sel);
    return base << sel;
  endfunction
endpackage

// File: rtl/drg_src_sel.sv
module drg_src_sel #(
  parameter int NRAIL = 4
) (
  input  logic [NRAIL-1:0]   uv_flag,
  input  logic [NRAIL-1:0]   ov_flag,
  input  logic [2*NRAIL-1:0] mask,
  input  logic               mr_n,
  input  logic               long_hit,
  output logic               trig
);
  logic [2*NRAIL-1:0] flags;

  assign flags = {ov_flag, uv_flag};
  // manual reset is ORed in after the mask so no mask bit can block it
  assign trig  = (|(flags & mask)) | ~mr_n | long_hit;
endmodule

// File: rtl/drg_pup_edge.sv
module drg_pup_edge #(
  parameter int NPUP  = 4,
  parameter int PUP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPUP-1:0]  pup_en,
  input  logic [PUP_W-1:0] pup_sel,
  output logic             rise
);
  logic cur;
  logic prev;

  assign cur  = pup_en[pup_sel];
  assign rise = cur & ~prev;

  // prev starts high so an enable that is already active at reset is not taken as an edge
  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= cur;
  end
endmodule

// File: rtl/drg_chan.sv
module drg_chan #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             early,
  input  logic [CNT_W-1:0] limit,
  output logic             held,
  output logic             rel
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = limit - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= 1'b1;
      cnt  <= '0;
      rel  <= 1'b0;
    end else begin
      rel <= 1'b0;
      if (trig) begin
        held <= 1'b1;
        cnt  <= '0;
      end else if (held) begin
        if (early || cnt == last) begin
          held <= 1'b0;
          cnt  <= '0;
          rel  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dual_reset_gen.sv
module dual_reset_gen #(
  parameter int NRAIL     = 4,
  parameter int NPUP      = 4,
  parameter int TSEL_W    = 2,
  parameter int PRTO_BASE = 8,
  localparam int PUP_W    = (NPUP > 1) ? $clog2(NPUP) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NRAIL-1:0]    uv_flag,
  input  logic [NRAIL-1:0]    ov_flag,
  input  logic [2*NRAIL-1:0]  mask_a,
  input  logic [2*NRAIL-1:0]  mask_b,
  input  logic                mr_n,
  input  logic                long_en,
  input  logic                long_tmo,
  input  logic                pwr_on_seq,
  input  logic [NPUP-1:0]     pup_en,
  input  logic [PUP_W-1:0]    pup_sel,
  input  logic [TSEL_W-1:0]   tmo_sel,
  output logic                rst_a_n,
  output logic                rst_b_n,
  output logic                rel_a,
  output logic                rel_b
);
  import drg_pkg::*;

  localparam int MAX_HOLD = PRTO_BASE << ((1 << TSEL_W) - 1);
  localparam int CNT_W    = $clog2(MAX_HOLD + 1);

  logic [CNT_W-1:0]   hold_cycles;
  logic               long_hit;
  logic               pup_rise;
  logic [2*NRAIL-1:0] mask_arr  [NOUT];
  logic [NOUT-1:0]    trig;
  logic [NOUT-1:0]    early;
  logic [NOUT-1:0]    held;
  logic [NOUT-1:0]    rel;

  assign hold_cycles    = CNT_W'(hold_len(PRTO_BASE, tmo_sel));
  assign long_hit       = long_en & long_tmo;
  assign mask_arr[CH_A] = mask_a;
  assign mask_arr[CH_B] = mask_b;

  drg_pup_edge #(.NPUP(NPUP), .PUP_W(PUP_W)) u_pup (
    .clk(clk), .rst_n(rst_n), .pup_en(pup_en), .pup_sel(pup_sel), .rise(pup_rise)
  );

  // only line A may be released early, and only with no trigger of its own present
  assign early[CH_A] = pwr_on_seq & pup_rise & ~trig[CH_A];
  assign early[CH_B] = 1'b0;

  for (genvar g = 0; g < NOUT; g++) begin : g_ch
    drg_src_sel #(.NRAIL(NRAIL)) u_src (
      .uv_flag(uv_flag), .ov_flag(ov_flag), .mask(mask_arr[g]),
      .mr_n(mr_n), .long_hit(long_hit), .trig(trig[g])
    );
    drg_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .trig(trig[g]), .early(early[g]),
      .limit(hold_cycles), .held(held[g]), .rel(rel[g])
    );
  end

  assign rst_a_n = ~held[CH_A];
  assign rst_b_n = ~held[CH_B];
  assign rel_a   = rel[CH_A];
  assign rel_b   = rel[CH_B];
endmodule

// File: rtl/drg_chk.sv
module drg_chk #(
  parameter int NRAIL     = 4,
  parameter int TSEL_W    = 2,
  parameter int PRTO_BASE = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NRAIL-1:0]   uv_flag,
  input logic [NRAIL-1:0]   ov_flag,
  input logic [2*NRAIL-1:0] mask_a,
  input logic [2*NRAIL-1:0] mask_b,
  input logic               mr_n,
  input logic               long_en,
  input logic               long_tmo,
  input logic               pwr_on_seq,
  input logic [TSEL_W-1:0]  tmo_sel,
  input logic               rst_a_n,
  input logic               rst_b_n,
  input logic               rel_a,
  input logic               rel_b
);
  localparam int MAX_HOLD = PRTO_BASE << ((1 << TSEL_W) - 1);
  localparam int QW       = $clog2(MAX_HOLD + 2);

  logic          hit_a, hit_b;
  logic [QW-1:0] qa, qb;
  int            hold;

  assign hit_a = (|({ov_flag, uv_flag} & mask_a)) | !mr_n | (long_en & long_tmo);
  assign hit_b = (|({ov_flag, uv_flag} & mask_b)) | !mr_n | (long_en & long_tmo);
  assign hold  = PRTO_BASE << tmo_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qa <= '0;
      qb <= '0;
    end else begin
      qa <= hit_a ? '0 : ((&qa) ? qa : qa + 1'b1);
      qb <= hit_b ? '0 : ((&qb) ? qb : qb + 1'b1);
    end
  end

  // R4
  mr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mr_n |=> (!rst_a_n && !rst_b_n));
  // R2
  fault_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|({ov_flag, uv_flag} & mask_a)) |=> !rst_a_n);
  // R2
  fault_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|({ov_flag, uv_flag} & mask_b)) |=> !rst_b_n);
  // R5
  long_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (long_en && long_tmo) |=> (!rst_a_n && !rst_b_n));
  // R9
  rel_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_a |-> (rst_a_n && !$past(rst_a_n)));
  // R9
  rel_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_b |-> (rst_b_n && !$past(rst_b_n)));
  // R3
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_b_n && !$past(rst_b_n)) |-> (int'(qb) == hold));
  // R8
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_a_n && !$past(rst_a_n) && !$past(pwr_on_seq)) |-> (int'(qa) == hold));
endmodule

bind dual_reset_gen drg_chk #(.NRAIL(NRAIL), .TSEL_W(TSEL_W), .PRTO_BASE(PRTO_BASE)) u_chk (.*);

// File: tb/dual_reset_gen_bench.sv
`timescale 1ns/1ps
module dual_reset_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] uv_flag, ov_flag;
  logic [7:0] mask_a, mask_b;
  logic       mr_n, long_en, long_tmo, pwr_on_seq;
  logic [3:0] pup_en;
  logic [1:0] pup_sel, tmo_sel;
  logic       rst_a_n, rst_b_n, rel_a, rel_b;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;
  int         hold;

  always #2.5 clk = ~clk;

  dual_reset_gen u_dual_reset_gen (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .mask_a(mask_a), .mask_b(mask_b), .mr_n(mr_n), .long_en(long_en),
    .long_tmo(long_tmo), .pwr_on_seq(pwr_on_seq), .pup_en(pup_en),
    .pup_sel(pup_sel), .tmo_sel(tmo_sel), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
    .rel_a(rel_a), .rel_b(rel_b)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic mr_pulse();
    mr_n = 1'b0;
    step(1);
    mr_n = 1'b1;
  endtask

  // after the last trigger cycle: low at H-1 edges, high with pulse at H edges
  task automatic expect_release(input string tag, input bit on_a, input bit on_b, input int already);
    step(hold - 1 - already);
    if (on_a) chk({tag, " A still low"}, rst_a_n, 1'b0);
    if (on_b) chk({tag, " B still low"}, rst_b_n, 1'b0);
    step(1);
    chk({tag, " A high"}, rst_a_n, 1'b1);
    chk({tag, " B high"}, rst_b_n, 1'b1);
    if (on_a) chk({tag, " R9 pulse A"}, rel_a, 1'b1);
    if (on_b) chk({tag, " R9 pulse B"}, rel_b, 1'b1);
    step(1);
    chk({tag, " R9 pulse A ends"}, rel_a, 1'b0);
    chk({tag, " R9 pulse B ends"}, rel_b, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; uv_flag = '0; ov_flag = '0; mask_a = '0; mask_b = '0;
    mr_n = 1'b1; long_en = 1'b0; long_tmo = 1'b0; pwr_on_seq = 1'b0;
    pup_en = '0; pup_sel = 2'd2; tmo_sel = 2'd0;
    hold = 8;
    step(3);
    chk("R1 reset A low", rst_a_n, 1'b0);
    chk("R1 reset B low", rst_b_n, 1'b0);
    rst_n = 1'b1;
    expect_release("R1 power-up", 1, 1, 0);

    // R2 / R3: all pairs of selected mask bit and raised flag
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        bit ha, hb;
        logic [7:0] f;
        ha = (i == j);
        hb = (((i + 3) % 8) == j);
        mask_a = 8'(1 << i);
        mask_b = 8'(1 << ((i + 3) % 8));
        f = 8'(1 << j);
        uv_flag = f[3:0];
        ov_flag = f[7:4];
        step(2);
        chk("R2 line A vs mask", rst_a_n, !ha);
        chk("R2 line B vs mask", rst_b_n, !hb);
        uv_flag = '0;
        ov_flag = '0;
        if (ha || hb) expect_release("R3 fault hold", ha, hb, 0);
      end
    end
    mask_a = '0;
    mask_b = '0;

    // R4: manual reset with all masks cleared
    mr_n = 1'b0;
    step(5);
    chk("R4 MR A low", rst_a_n, 1'b0);
    chk("R4 MR B low", rst_b_n, 1'b0);
    mr_n = 1'b1;
    expect_release("R4 MR hold", 1, 1, 0);

    // R6: trigger reappears mid-count
    mr_pulse();
    step(5);
    chk("R6 mid-count A low", rst_a_n, 1'b0);
    mr_pulse();
    expect_release("R6 restart", 1, 1, 0);

    // R5: long timer
    long_tmo = 1'b1;
    step(1);
    long_tmo = 1'b0;
    chk("R5 disabled A", rst_a_n, 1'b1);
    chk("R5 disabled B", rst_b_n, 1'b1);
    long_en = 1'b1;
    long_tmo = 1'b1;
    step(1);
    long_tmo = 1'b0;
    chk("R5 enabled A low", rst_a_n, 1'b0);
    chk("R5 enabled B low", rst_b_n, 1'b0);
    expect_release("R5 hold", 1, 1, 0);
    long_en = 1'b0;

    // R10: each hold setting
    for (int s = 1; s < 4; s++) begin
      tmo_sel = 2'(s);
      hold = 8 << s;
      mr_pulse();
      expect_release("R10 hold length", 1, 1, 0);
    end
    tmo_sel = 2'd0;
    hold = 8;

    // R7: early release of A
    pwr_on_seq = 1'b1;
    mr_pulse();
    step(2);
    pup_en = 4'b0100;
    step(1);
    chk("R7 A released early", rst_a_n, 1'b1);
    chk("R7 pulse A", rel_a, 1'b1);
    chk("R7 B still low", rst_b_n, 1'b0);
    expect_release("R7 B hold", 0, 1, 3);
    pup_en = '0;
    step(1);

    // R8: fault present blocks early release
    mask_a = 8'h01;
    uv_flag = 4'h1;
    step(2);
    pup_en = 4'b0100;
    step(1);
    chk("R8 fault blocks early", rst_a_n, 1'b0);
    uv_flag = '0;
    expect_release("R8 fault hold", 1, 0, 0);
    mask_a = '0;
    pup_en = '0;
    step(1);

    // R8: not sequencing
    pwr_on_seq = 1'b0;
    mr_pulse();
    step(2);
    pup_en = 4'b0100;
    step(1);
    chk("R8 no sequencing A low", rst_a_n, 1'b0);
    expect_release("R8 no sequencing", 1, 1, 3);
    pup_en = '0;
    step(1);

    // R8: unselected enable bit
    pwr_on_seq = 1'b1;
    mr_pulse();
    step(2);
    pup_en = 4'b0001;
    step(1);
    chk("R8 wrong bit A low", rst_a_n, 1'b0);
    expect_release("R8 wrong bit", 1, 1, 3);
    pup_en = '0;
    step(1);

    // R8: A already high, no pulse
    pup_en = 4'b0100;
    step(1);
    chk("R8 idle A high", rst_a_n, 1'b1);
    chk("R8 idle no pulse", rel_a, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule